// File: doc/BRIEF.md
# Asymmetric Center-Aligned Complementary PWM Pair

This block drives one complementary pair of PWM outputs, an even output and an odd output, from a counter that runs up and then down once per PWM period. The pair is asymmetric. While the counter rises, the even compare value sets how long the even output is active before the turning point. While it falls, the odd compare value sets how long the even output stays active after the turning point. The odd output is the complement of the even output. A programmable dead time separates the two, so the output that is turning on waits a set number of clock cycles.

Software writes compare values into holding registers at any time. The values reach the active registers only after a load-ok strobe. The transfer then happens at the next reload point. The start of each period is always a reload point. When half-cycle reload is enabled, the turning point in the middle of the period is one as well. When both active compare values are zero, the pair is disabled and both outputs stay low. The disable decision is registered in the same stage as the waveform, so zeroing the two values in any order produces no short dead-time-wide pulse on the odd output.

Top module: `cpwm_pair`

## Requirements
- R1: While reset is asserted, and for the two clock edges after reset is released, both PWM outputs are low and `ldok_o` is low.
- R2: One period lasts 2*MOD clock cycles. The up half covers period positions 0..MOD-1, with the counter value equal to the position. The down half covers positions MOD..2*MOD-1, with the counter value equal to 2*MOD minus the position. The outputs reflect each position one clock cycle later.
- R3: In the up half, the raw even level is active for the last E positions, where E is the active even value. If E is MOD or more, it is active for the whole up half.
- R4: In the down half, the raw even level is active for the first O positions, where O is the active odd value. If O is MOD or more, it is active for the whole down half.
- R5: A write to a holding register has no effect on the outputs until a load-ok strobe has set `ldok_o`. The transfer then takes place at the next reload point, and `ldok_o` returns to 0 at that same edge.
- R6: With `half_reload_i` low, only the edge into position 0 transfers pending values. With it high, the edge into position MOD transfers them as well.
- R7: Transfers use the flag and the holding values as they stood before the edge. A load-ok strobe on a reload edge leaves `ldok_o` at 1 for the next point. A write on a transfer edge is kept for a later transfer, and the earlier holding value is the one applied.
- R8: After the raw level or the enable changes, the output that turns on waits `dead_i` clock cycles. The output that turns off falls at once. A value of 0 means no delay.
- R9: Outside the dead-time gaps, the odd output is the inverse of the even output while the pair is enabled.
- R10: While both active values are zero, both outputs are low. When the pair is re-enabled, the output that turns on still waits the dead time.
- R11: The odd output shows no pulse after the full-cycle reload that disables the pair. This holds when the odd zero is loaded at a half-cycle point and the even zero at the next full-cycle point, and also when both zeros are loaded at the same full-cycle point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_even_i | input | CNT_W | Even compare value to be held |
| wr_even_i | input | 1 | Writes `cmp_even_i` into the even holding register |
| cmp_odd_i | input | CNT_W | Odd compare value to be held |
| wr_odd_i | input | 1 | Writes `cmp_odd_i` into the odd holding register |
| ldok_set_i | input | 1 | Load-ok strobe; arms a transfer at the next reload point |
| half_reload_i | input | 1 | Enables reload at the mid-period turning point |
| dead_i | input | DT_W | Dead time in clock cycles |
| pwm_even_o | output | 1 | Even PWM output |
| pwm_odd_o | output | 1 | Odd PWM output |
| ldok_o | output | 1 | Transfer pending flag |

## Verification
Two functions can fall in the same clock cycle: a reload transfer, and a software write or load-ok strobe arriving on that very edge. The bench provokes this on purpose. It raises the strobe on the edge into position 0 while no transfer is pending. It writes a new even value on the edge of an armed half-cycle transfer. It then judges the outcome from the flag and from the count of active even cycles over the next period. Random traffic adds more overlaps. Each of these is compared cycle by cycle against a position-based model of the waveform. The bench also runs both zeroing orders against a dead time of three cycles. It requires the odd output to stay low for a whole period after the disabling reload.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;

  // Marks that the coming clock edge lands on a reload point
  typedef struct packed {
    logic full;   // edge into period start
    logic half;   // edge into mid-period turning point
  } reload_pt_t;

endpackage

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
  parameter int CNT_W = 16,
  parameter int MOD   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [CNT_W-1:0]      ctr_o,
  output cpwm_pkg::cnt_dir_e    dir_o,
  output cpwm_pkg::reload_pt_t  pt_o
);
  import cpwm_pkg::*;

  localparam logic [CNT_W-1:0] TOP     = CNT_W'(MOD);
  localparam logic [CNT_W-1:0] LAST_UP = CNT_W'(MOD - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] ctr_q, ctr_d;
  cnt_dir_e         dir_q, dir_d;
  reload_pt_t       pt;
  logic             cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    ctr_d = ctr_q;
    dir_d = dir_q;
    pt    = '0;
    if (dir_q == DIR_UP) begin
      if (ctr_q == LAST_UP) begin
        ctr_d   = TOP;
        dir_d   = DIR_DOWN;
        pt.half = 1'b1;
      end else begin
        ctr_d = ctr_q + ONE;
      end
    end else begin
      if (ctr_q == ONE) begin
        ctr_d   = '0;
        dir_d   = DIR_UP;
        pt.full = 1'b1;
      end else begin
        ctr_d = ctr_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q <= '0;
      dir_q <= DIR_UP;
    end else if (cnt_en) begin
      ctr_q <= ctr_d;
      dir_q <= dir_d;
    end
  end

  assign ctr_o = ctr_q;
  assign dir_o = dir_q;
  assign pt_o  = pt;

  // R2
  ctr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_q <= TOP) && ((dir_q == DIR_DOWN) || (ctr_q < TOP)));

  // R2
  dir_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == DIR_UP && ctr_q == LAST_UP) |=> (dir_q == DIR_DOWN && ctr_q == TOP));

endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      cmp_even_i,
  input  logic                  wr_even_i,
  input  logic [CNT_W-1:0]      cmp_odd_i,
  input  logic                  wr_odd_i,
  input  logic                  ldok_set_i,
  input  logic                  half_reload_i,
  input  cpwm_pkg::reload_pt_t  pt_i,
  output logic [CNT_W-1:0]      act_even_o,
  output logic [CNT_W-1:0]      act_odd_o,
  output logic                  ldok_o
);

  logic [CNT_W-1:0] hold_e_q, hold_e_d, hold_o_q, hold_o_d;
  logic [CNT_W-1:0] act_e_q, act_e_d, act_o_q, act_o_d;
  logic             ldok_q, ldok_d;
  logic             take;

  always_comb begin
    take     = ldok_q & (pt_i.full | (pt_i.half & half_reload_i));
    hold_e_d = wr_even_i ? cmp_even_i : hold_e_q;
    hold_o_d = wr_odd_i  ? cmp_odd_i  : hold_o_q;
    act_e_d  = take ? hold_e_q : act_e_q;
    act_o_d  = take ? hold_o_q : act_o_q;
    ldok_d   = ldok_set_i | (ldok_q & ~take);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_e_q <= '0;
      hold_o_q <= '0;
    end else begin
      if (wr_even_i) hold_e_q <= hold_e_d;
      if (wr_odd_i)  hold_o_q <= hold_o_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_e_q <= '0;
      act_o_q <= '0;
      ldok_q  <= 1'b0;
    end else begin
      if (take) begin
        act_e_q <= act_e_d;
        act_o_q <= act_o_d;
      end
      ldok_q <= ldok_d;
    end
  end

  assign act_even_o = act_e_q;
  assign act_odd_o  = act_o_q;
  assign ldok_o     = ldok_q;

  // R5
  ldok_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ldok_q) |-> $past(pt_i.full || (pt_i.half && half_reload_i)));

  // R5
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pt_i.full || pt_i.half) |=> ($stable(act_e_q) && $stable(act_o_q)));

endmodule

// File: rtl/cpwm_shape.sv
module cpwm_shape #(
  parameter int CNT_W = 16,
  parameter int MOD   = 16
) (
  input  logic [CNT_W-1:0]   ctr_i,
  input  cpwm_pkg::cnt_dir_e dir_i,
  input  logic [CNT_W-1:0]   act_even_i,
  input  logic [CNT_W-1:0]   act_odd_i,
  output logic               raw_o,
  output logic               en_o
);
  import cpwm_pkg::*;

  localparam logic [CNT_W-1:0] TOP = CNT_W'(MOD);

  logic e_sat, o_sat, e_hit, o_hit;

  always_comb begin
    e_sat = (act_even_i >= TOP);
    o_sat = (act_odd_i  >= TOP);
    e_hit = e_sat | (ctr_i >= (TOP - act_even_i));
    o_hit = o_sat | (ctr_i >  (TOP - act_odd_i));
    raw_o = (dir_i == DIR_UP) ? e_hit : o_hit;
    en_o  = (|act_even_i) | (|act_odd_i);
  end

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic            en_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            even_o,
  output logic            odd_o
);

  localparam logic [DT_W-1:0] SAT = {DT_W{1'b1}};

  logic            raw_q, en_q;
  logic [DT_W-1:0] settle_q, settle_d;
  logic            moved, ready;

  always_comb begin
    moved = (raw_i != raw_q) || (en_i != en_q);
    if (moved)                settle_d = '0;
    else if (settle_q != SAT) settle_d = settle_q + 1'b1;
    else                      settle_d = settle_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q    <= 1'b0;
      en_q     <= 1'b0;
      settle_q <= '0;
    end else begin
      raw_q    <= raw_i;
      en_q     <= en_i;
      settle_q <= settle_d;
    end
  end

  assign ready  = (settle_q >= dead_i);
  assign even_o = en_q &  raw_q & ready;
  assign odd_o  = en_q & ~raw_q & ready;

  // R8
  dt_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(even_o) && dead_i != '0) |-> !odd_o);

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
  parameter int CNT_W = 16,
  parameter int MOD   = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cmp_even_i,
  input  logic             wr_even_i,
  input  logic [CNT_W-1:0] cmp_odd_i,
  input  logic             wr_odd_i,
  input  logic             ldok_set_i,
  input  logic             half_reload_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             pwm_even_o,
  output logic             pwm_odd_o,
  output logic             ldok_o
);
  import cpwm_pkg::*;

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [CNT_W-1:0] ctr;
  cnt_dir_e         dir;
  reload_pt_t       pt;
  logic [CNT_W-1:0] act_e, act_o;
  logic             raw, en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  cpwm_updown #(.CNT_W(CNT_W), .MOD(MOD)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .ctr_o  (ctr),
    .dir_o  (dir),
    .pt_o   (pt)
  );

  cpwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .cmp_even_i    (cmp_even_i),
    .wr_even_i     (wr_even_i),
    .cmp_odd_i     (cmp_odd_i),
    .wr_odd_i      (wr_odd_i),
    .ldok_set_i    (ldok_set_i),
    .half_reload_i (half_reload_i),
    .pt_i          (pt),
    .act_even_o    (act_e),
    .act_odd_o     (act_o),
    .ldok_o        (ldok_o)
  );

  cpwm_shape #(.CNT_W(CNT_W), .MOD(MOD)) u_shape (
    .ctr_i      (ctr),
    .dir_i      (dir),
    .act_even_i (act_e),
    .act_odd_i  (act_o),
    .raw_o      (raw),
    .en_o       (en)
  );

  cpwm_deadband #(.DT_W(DT_W)) u_db (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .raw_i  (raw),
    .en_i   (en),
    .dead_i (dead_i),
    .even_o (pwm_even_o),
    .odd_o  (pwm_odd_o)
  );

  // R10
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (act_e == '0 && act_o == '0) |=> (!pwm_odd_o && !pwm_even_o));

endmodule

// File: tb/cpwm_pair_tb.sv
`timescale 1ns/1ps
module cpwm_pair_tb;
  localparam int CW = 16;
  localparam int M  = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cmp_e, cmp_o;
  logic          wr_e, wr_o, ldset, hen;
  logic [DW-1:0] dead;
  logic          pwm_e, pwm_o, ldok;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_pos, m_ae, m_ao, m_he, m_ho, m_settle;
  bit m_ldok, m_rawq, m_enq;

  always #2.5 clk = ~clk;

  cpwm_pair #(.CNT_W(CW), .MOD(M), .DT_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmp_even_i(cmp_e), .wr_even_i(wr_e),
    .cmp_odd_i(cmp_o), .wr_odd_i(wr_o),
    .ldok_set_i(ldset), .half_reload_i(hen), .dead_i(dead),
    .pwm_even_o(pwm_e), .pwm_odd_o(pwm_o), .ldok_o(ldok)
  );

  // Raw even level at a period position, from R2/R3/R4
  function automatic bit raw_at(int pos, int e, int o);
    int c;
    if (pos < M) return (e >= M) || (pos >= M - e);
    c = 2*M - pos;
    return (o >= M) || (c > M - o);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit nr, ne, xe, xo, rdy;
    int np;
    @(posedge clk);
    nr = raw_at(m_pos, m_ae, m_ao);
    ne = (m_ae != 0) || (m_ao != 0);
    if (nr != m_rawq || ne != m_enq) m_settle = 0;
    else if (m_settle < 255) m_settle++;
    m_rawq = nr;
    m_enq  = ne;
    np = (m_pos + 1) % (2*M);
    if (m_ldok && (np == 0 || (np == M && hen))) begin
      m_ae = m_he; m_ao = m_ho; m_ldok = 0;
    end
    if (ldset) m_ldok = 1;
    if (wr_e) m_he = int'(cmp_e);
    if (wr_o) m_ho = int'(cmp_o);
    m_pos = np;
    @(negedge clk);
    rdy = (m_settle >= int'(dead));
    xe  = m_enq && m_rawq && rdy;
    xo  = m_enq && !m_rawq && rdy;
    chk(pwm_e == xe, tag, "even", int'(pwm_e), int'(xe));
    chk(pwm_o == xo, tag, "odd", int'(pwm_o), int'(xo));
    chk(ldok == m_ldok, tag, "ldok", int'(ldok), int'(m_ldok));
    wr_e = 0; wr_o = 0; ldset = 0;
  endtask

  task automatic run_to(int p, string tag);
    while (m_pos != p) step(tag);
  endtask

  task automatic load(int e, int o);
    cmp_e = CW'(e); wr_e = 1;
    cmp_o = CW'(o); wr_o = 1;
    ldset = 1;
  endtask

  // Count high cycles of each output over one full period
  task automatic count_period(string tag, output int ne, output int no);
    ne = 0; no = 0;
    for (int i = 0; i < 2*M; i++) begin
      step(tag);
      ne += int'(pwm_e);
      no += int'(pwm_o);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ce, co, bad, seed;
    rst_n = 0; cmp_e = '0; cmp_o = '0; wr_e = 0; wr_o = 0;
    ldset = 0; hen = 0; dead = '0;
    m_pos = 0; m_ae = 0; m_ao = 0; m_he = 0; m_ho = 0; m_settle = 0;
    m_ldok = 0; m_rawq = 0; m_enq = 0;
    seed = $urandom(32'd2024);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!pwm_e && !pwm_o && !ldok, "R1", "in reset", int'(pwm_e | pwm_o | ldok), 0);
    rst_n = 1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!pwm_e && !pwm_o && !ldok, "R1", "sync release", int'(pwm_e | pwm_o | ldok), 0);
    end

    // R5: write without strobe has no effect
    dead = DW'(2);
    cmp_e = CW'(4); wr_e = 1; cmp_o = CW'(3); wr_o = 1;
    for (int i = 0; i < 2*M + 4; i++) step("R5");
    chk(ldok == 0, "R5", "flag idle", int'(ldok), 0);
    chk(pwm_e == 0, "R5", "no strobe output", int'(pwm_e), 0);
    ldset = 1;
    step("R5");
    chk(ldok == 1, "R5", "flag set", int'(ldok), 1);
    run_to(0, "R5");
    chk(ldok == 0, "R5", "flag cleared", int'(ldok), 0);
    for (int i = 0; i < 2*M; i++) step("R3/R4");

    // R6: half reload disabled, then enabled
    run_to(2, "R6");
    cmp_e = CW'(6); wr_e = 1; ldset = 1;
    run_to(M, "R6");
    chk(ldok == 1, "R6", "no half transfer", int'(ldok), 1);
    run_to(0, "R6");
    chk(ldok == 0, "R6", "full transfer", int'(ldok), 0);
    hen = 1;
    run_to(2, "R6");
    cmp_o = CW'(9); wr_o = 1; ldset = 1;
    run_to(M, "R6");
    chk(ldok == 0, "R6", "half transfer", int'(ldok), 0);

    // R7: strobe on reload edge, write on transfer edge
    dead = '0;
    run_to(2*M - 1, "R7");
    cmp_e = CW'(10); wr_e = 1; ldset = 1;
    step("R7");
    chk(ldok == 1, "R7", "strobe at reload", int'(ldok), 1);
    run_to(M - 1, "R7");
    cmp_e = CW'(2); wr_e = 1;
    step("R7");
    chk(ldok == 0, "R7", "transfer at half", int'(ldok), 0);
    run_to(0, "R7");
    count_period("R7", ce, co);
    chk(ce == 19, "R7", "old value applied", ce, 19);

    // R3 saturation of even value
    run_to(2, "R3");
    load(M + 3, 9);
    run_to(0, "R3");
    count_period("R3", ce, co);
    chk(ce == M + 9, "R3", "even saturates", ce, M + 9);

    // R4 saturation of odd value
    run_to(2, "R4");
    load(0, M);
    run_to(0, "R4");
    count_period("R4", ce, co);
    chk(ce == M, "R4", "odd saturates", ce, M);
    chk(co == M, "R4", "odd output half", co, M);

    // R8 / R9 dead time and complement
    dead = DW'(3);
    run_to(2, "R8");
    load(5, 4);
    run_to(0, "R8");
    for (int i = 0; i < 2*M; i++) step("R8/R9");
    count_period("R8", ce, co);
    chk(ce == 6, "R8", "even width minus dead", ce, 6);
    chk(co == 20, "R9", "odd width minus dead", co, 20);

    // R10 disable and re-enable
    run_to(2, "R10");
    load(0, 0);
    run_to(0, "R10");
    step("R10");
    count_period("R10", ce, co);
    chk(ce + co == 0, "R10", "disabled quiet", ce + co, 0);
    dead = DW'(4);
    run_to(2, "R10");
    load(3, 3);
    run_to(0, "R10");
    for (int i = 0; i < 2*M; i++) step("R10");

    // R11 case A: odd zero at half point, even zero at next full point
    dead = DW'(3);
    hen = 1;
    run_to(2, "R11");
    load(5, 7);
    run_to(0, "R11");
    run_to(2, "R11");
    cmp_o = '0; wr_o = 1; ldset = 1;
    run_to(M + 2, "R11");
    cmp_e = '0; wr_e = 1; ldset = 1;
    run_to(0, "R11");
    step("R11");
    bad = 0;
    for (int i = 0; i < 2*M; i++) begin
      step("R11");
      bad += int'(pwm_o);
    end
    chk(bad == 0, "R11", "odd quiet case A", bad, 0);

    // R11 case B: both zeros at the same full point
    run_to(2, "R11");
    load(5, 7);
    run_to(0, "R11");
    run_to(M + 2, "R11");
    load(0, 0);
    run_to(0, "R11");
    step("R11");
    bad = 0;
    for (int i = 0; i < 2*M; i++) begin
      step("R11");
      bad += int'(pwm_o);
    end
    chk(bad == 0, "R11", "odd quiet case B", bad, 0);

    // Random traffic: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0) begin
        cmp_e = ($urandom % 4 == 0) ? '0 : CW'($urandom % (M + 4)); wr_e = 1;
      end
      if ($urandom % 8 == 0) begin
        cmp_o = ($urandom % 4 == 0) ? '0 : CW'($urandom % (M + 4)); wr_o = 1;
      end
      if ($urandom % 12 == 0) ldset = 1;
      if ($urandom % 300 == 0) hen = ~hen;
      if ($urandom % 400 == 0) dead = DW'($urandom % 5);
      step("R2/R3/R4/R8/R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule